// File: doc/BRIEF.md
# Shared-Wire Four-Phase Handshake Sequencer

This block turns one four-phase handshake on its upstream side into a nested pair. When the upstream request arrives, the block runs one complete four-phase handshake on its downstream side. Only after that handshake has returned to zero does it acknowledge upstream. The upstream party then withdraws its request, and the acknowledge falls to end the cycle.

The downstream request and acknowledge wires are meant to be shared by several such sequencers. An arbiter upstream lets only one of them hold its request at a time. The shared acknowledge can therefore toggle while a given sequencer is idle, and also while it sits in its acknowledged phase. The block must ignore that activity.

One internal phase bit separates the part of the cycle before the downstream acknowledge from the part after it. The block is a clocked, synthesizable emulation of the self-timed circuit: every signal is evaluated once per clock edge. An enable input can hold off the start of a new cycle, and it never interrupts a cycle that has already begun.

Top module: `hsq_seq`

## Requirements
- R1: After reset, rreq_o and lack_o are low and the block is idle; the phase bit reads "before downstream acknowledge".
- R2: Suppose the block is idle and, at a clock edge, lreq_i and en_i are both sampled high. Then rreq_o is high after that edge.
- R3: rreq_o stays high while rack_i is sampled low. It falls at the second clock edge after rack_i is first sampled high.
- R4: lack_o rises only while rreq_o is low. It rises at the edge where rack_i is first sampled low after the downstream acknowledge was seen.
- R5: lack_o stays high while lreq_i stays high, whatever rack_i does. It falls at the second clock edge after lreq_i is sampled low.
- R6: While the block is idle with lreq_i low, any activity on rack_i leaves rreq_o and lack_o low.
- R7: While en_i is low, an idle block does not raise rreq_o, even with lreq_i high and rack_i toggling. Lowering en_i after rreq_o has risen does not stop the cycle.
- R8: rreq_o and lack_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Permits the start of a new cycle when high |
| lreq_i | input | 1 | Upstream four-phase request |
| lack_o | output | 1 | Upstream four-phase acknowledge |
| rreq_o | output | 1 | Downstream request (wire-ORed with other sequencers) |
| rack_i | input | 1 | Downstream acknowledge, shared with other sequencers |

## Verification
The assertions check the following on every cycle:
- rreq_o and lack_o are mutually exclusive.
- rreq_o rises only on a sampled request.
- lack_o rises only after a low downstream acknowledge.
- The upstream acknowledge is held while the request is held.
- An idle block stays quiet, and a low enable blocks a start.

Only the bench scenarios can show the exact edge counts of each phase and the full event order across two sequencers sharing the downstream wires. The same applies to immunity to acknowledge toggles injected while idle, while blocked by the enable, and while acknowledged.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  typedef struct packed {
    logic req;   // downstream request
    logic ack;   // upstream acknowledge
    logic hold;  // phase bit: high before downstream ack is seen
  } hsq_state_t;

  localparam hsq_state_t HSQ_RESET = '{req: 1'b0, ack: 1'b0, hold: 1'b1};
endpackage

// File: rtl/hsq_gate.sv
module hsq_gate
  import hsq_pkg::*;
#(
  parameter bit USE_EN = 1'b1
) (
  input  logic       lreq_i,
  input  logic       en_i,
  input  hsq_state_t st_i,
  output logic       go_o
);
  generate
    if (USE_EN) begin : g_en
      logic busy;
      // a cycle is under way once any state departs from idle
      assign busy = st_i.req | ~st_i.hold | st_i.ack;
      assign go_o = lreq_i & (en_i | busy);
    end else begin : g_noen
      logic unused_en;
      assign unused_en = en_i;
      assign go_o = lreq_i;
    end
  endgenerate
endmodule

// File: rtl/hsq_next.sv
module hsq_next
  import hsq_pkg::*;
(
  input  hsq_state_t st_i,
  input  logic       go_i,
  input  logic       rack_i,
  output hsq_state_t nxt_o
);
  always_comb begin
    // downstream request: asserted only before the phase flip
    nxt_o.req  = go_i & st_i.hold;
    // upstream ack: set by low rack once past the flip, reset by phase bit
    nxt_o.ack  = ~st_i.hold & (st_i.ack | ~rack_i);
    // phase bit: cleared by rack, set again by request withdrawal
    nxt_o.hold = (~rack_i & st_i.hold) | ~go_i;
  end
endmodule

// File: rtl/hsq_regs.sv
module hsq_regs
  import hsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hsq_state_t nxt_i,
  output hsq_state_t st_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_o <= HSQ_RESET;
    else        st_o <= nxt_i;
  end
endmodule

// File: rtl/hsq_seq.sv
module hsq_seq
  import hsq_pkg::*;
#(
  parameter bit USE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lreq_i,
  output logic lack_o,
  output logic rreq_o,
  input  logic rack_i
);
  hsq_state_t st, nxt;
  logic       go;

  hsq_gate #(.USE_EN(USE_EN)) u_gate (
    .lreq_i(lreq_i), .en_i(en_i), .st_i(st), .go_o(go)
  );
  hsq_next u_next (.st_i(st), .go_i(go), .rack_i(rack_i), .nxt_o(nxt));
  hsq_regs u_regs (.clk(clk), .rst_n(rst_n), .nxt_i(nxt), .st_o(st));

  assign rreq_o = st.req;
  assign lack_o = st.ack;

  // R8
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rreq_o && lack_o));

  // R2
  p_rise_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_o) |-> $past(lreq_i));

  // R3
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_o && lreq_i && !rack_i && st.hold |=> rreq_o);

  // R4
  p_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lack_o) |-> (!rreq_o && !$past(rack_i)));

  // R5
  p_ack_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lack_o && lreq_i |=> lack_o);

  // R6
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lreq_i && !lack_o |=> (!rreq_o && !lack_o));

  generate
    if (USE_EN) begin : g_en_chk
      // R7
      p_en_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !rreq_o && !lack_o && st.hold |=> !rreq_o);
    end
  endgenerate
endmodule

// File: tb/test_hsq_seq.sv
module test_hsq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSEQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic noise = 1'b0;
  logic resp_ack = 1'b0;
  logic [NSEQ-1:0] lreq = '0;
  logic [NSEQ-1:0] rreq_w, lack_w;
  logic rack, rreq_sh;
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  assign rreq_sh = |rreq_w;
  assign rack = resp_ack | noise;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NSEQ; g++) begin : g_dut
    hsq_seq i_hsq_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en), .lreq_i(lreq[g]),
      .lack_o(lack_w[g]), .rreq_o(rreq_w[g]), .rack_i(rack)
    );
  end

  // behavioural responder on the shared downstream wires
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) resp_ack <= 1'b0;
    else        resp_ack <= rreq_sh;

  // reference model: one phase per sequencer, advanced at each edge
  typedef enum logic [2:0] {M_IDLE, M_REQ, M_DROP, M_WLOW, M_ACKD, M_REL} ph_t;
  ph_t ph [NSEQ];

  always_ff @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < NSEQ; k++) begin
      if (!rst_n) ph[k] <= M_IDLE;
      else case (ph[k])
        M_IDLE:  if (lreq[k] && en) ph[k] <= M_REQ;
        M_REQ:   if (rack) ph[k] <= M_DROP;
        M_DROP:  ph[k] <= rack ? M_WLOW : M_ACKD;
        M_WLOW:  if (!rack) ph[k] <= M_ACKD;
        M_ACKD:  if (!lreq[k]) ph[k] <= M_REL;
        default: ph[k] <= M_IDLE;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < NSEQ; k++) begin
        chk(rreq_w[k] == (ph[k] == M_REQ || ph[k] == M_DROP),
            $sformatf("R3 rreq seq%0d", k), rreq_w[k],
            (ph[k] == M_REQ || ph[k] == M_DROP));
        chk(lack_w[k] == (ph[k] == M_ACKD || ph[k] == M_REL),
            $sformatf("R4 lack seq%0d", k), lack_w[k],
            (ph[k] == M_ACKD || ph[k] == M_REL));
        chk(!(rreq_w[k] && lack_w[k]), $sformatf("R8 excl seq%0d", k),
            rreq_w[k] & lack_w[k], 0);
      end
      chk($countones(lreq) <= 1, "R6 arbiter one-hot", $countones(lreq), 1);
    end
  end

  task automatic run_cycle(input int k, input bit noisy, input bit drop_en);
    @(negedge clk); lreq[k] = 1'b1;
    @(negedge clk);
    chk(rreq_w[k] == 1'b1, "R2 rreq after request", rreq_w[k], 1);
    if (drop_en) en = 1'b0;
    while (!lack_w[k]) @(negedge clk);
    if (noisy) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); noise = ~noise;
        chk(lack_w[k] == 1'b1, "R5 lack held under noise", lack_w[k], 1);
      end
      noise = 1'b0;
    end
    @(negedge clk); lreq[k] = 1'b0;
    @(negedge clk);
    chk(lack_w[k] == 1'b1, "R5 lack one edge after release", lack_w[k], 1);
    @(negedge clk);
    chk(lack_w[k] == 1'b0, "R5 lack low two edges after release", lack_w[k], 0);
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < NSEQ; k++) begin
      chk(rreq_w[k] == 1'b0, "R1 reset rreq", rreq_w[k], 0);
      chk(lack_w[k] == 1'b0, "R1 reset lack", lack_w[k], 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cycle(0, 1'b0, 1'b0);
    run_cycle(1, 1'b1, 1'b0);

    // R6: shared ack toggles while everyone is idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); noise = (i % 3) != 0;
      chk(rreq_sh == 1'b0 && lack_w == '0, "R6 idle immune", {rreq_sh, lack_w}, 0);
    end
    @(negedge clk); noise = 1'b0;

    // R7: enable low holds off a pending request, even with ack noise
    en = 1'b0;
    @(negedge clk); lreq[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); noise = i[0];
      chk(rreq_w[0] == 1'b0 && lack_w[0] == 1'b0, "R7 blocked start",
          {rreq_w[0], lack_w[0]}, 0);
    end
    noise = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk(rreq_w[0] == 1'b1, "R7 start after enable", rreq_w[0], 1);
    while (!lack_w[0]) @(negedge clk);
    @(negedge clk); lreq[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R7: enable dropped mid-cycle, cycle completes
    run_cycle(1, 1'b0, 1'b1);
    run_cycle(0, 1'b1, 1'b1);
    run_cycle(1, 1'b1, 1'b0);
    run_cycle(0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule